// File: doc/BRIEF.md
# Tagged TLB Lookup Unit

This block is a small, fully associative translation buffer. It turns a 32-bit effective address into a 32-bit real address. Each lookup carries the instruction-space and data-space flags, a fetch/data selector and the current process identifier. An entry takes part in a translation only when it is valid and its page number matches. Its address-space tag must also match, and its process tag must either equal the current identifier or be zero. A zero process tag marks a page that every process shares.

Translation is combinational. The hit flag, the index of the winning entry, the real address and the permission bits all appear in the same cycle as the request. Each entry has its own page-size code, from 4 KB to 1 MB. Effective-address bits below the page boundary are left out of the compare and are copied into the real address.

Software never writes the table directly. It fills a set of staging registers, then issues a write command that copies the staging set into a chosen slot. A read command copies a chosen slot back into the staging set.

Top module: `tlb_lookup_unit`

## Requirements
- R1: An entry matches only when its valid bit is 1, its space tag equals the selected space bit, and its effective page number equals the request's page number on every bit above the page boundary.
- R2: When req_fetch is 1 the space bit used is fetch_space; when req_fetch is 0 it is data_space.
- R3: The process tag of an entry must equal cur_pid, except that a tag of zero matches any cur_pid.
- R4: Size code 0/1/2/3/4 selects 4 KB/16 KB/64 KB/256 KB/1 MB, so the offset is 12+2*code bits wide. Codes 5 to 7 act as 4 KB. Offset bits are excluded from the compare and copied from req_ea into real_addr, and the remaining bits come from the entry's real page number.
- R5: hit, hit_idx, real_addr and perm_out are valid in the same cycle as the request. When req_valid is 0 or nothing matches, hit is 0 and hit_idx, real_addr and perm_out are all 0.
- R6: When two or more entries match, multi_hit is 1 and the lowest-index match supplies the outputs.
- R7: miss_pulse is 1 for exactly the one cycle after each cycle in which req_valid was 1 and hit was 0, and is 0 otherwise.
- R8: With cmd_write at a clock edge, the staging set as it stood before that edge is copied into the slot at cmd_idx. A lookup in the next cycle sees the new contents, and a lookup in the same cycle still sees the old ones.
- R9: With cmd_read at a clock edge, the slot at cmd_idx is copied into the staging set. A read takes priority over ld_en in the same cycle.
- R10: Reset clears every valid bit, the staging set and miss_pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Lookup request present |
| req_fetch | input | 1 | 1 = instruction fetch, 0 = data access |
| req_ea | input | 32 | Effective address |
| fetch_space | input | 1 | Instruction address-space flag |
| data_space | input | 1 | Data address-space flag |
| cur_pid | input | PID_W | Current process identifier |
| hit | output | 1 | Translation found |
| multi_hit | output | 1 | More than one entry matched |
| hit_idx | output | IDX_W | Index of the winning entry |
| real_addr | output | 32 | Translated address, zero on miss |
| perm_out | output | PERM_W | Permission bits of the winner, zero on miss |
| miss_pulse | output | 1 | One-cycle strobe after a missed request |
| ld_en | input | 1 | Load staging set from ld_* inputs |
| ld_valid | input | 1 | Staging valid bit value |
| ld_space | input | 1 | Staging space tag value |
| ld_tid | input | PID_W | Staging process tag value |
| ld_epn | input | 20 | Staging effective page number value |
| ld_rpn | input | 20 | Staging real page number value |
| ld_size | input | 3 | Staging size code value |
| ld_perm | input | PERM_W | Staging permission value |
| cmd_write | input | 1 | Copy staging set into slot cmd_idx |
| cmd_read | input | 1 | Copy slot cmd_idx into staging set |
| cmd_idx | input | IDX_W | Slot chosen by a command |
| st_valid | output | 1 | Staging valid bit |
| st_space | output | 1 | Staging space tag |
| st_tid | output | PID_W | Staging process tag |
| st_epn | output | 20 | Staging effective page number |
| st_rpn | output | 20 | Staging real page number |
| st_size | output | 3 | Staging size code |
| st_perm | output | PERM_W | Staging permissions |

## Verification
The assertions check several properties on every cycle. A miss or an idle request leaves the address, index and permission outputs at zero. multi_hit never appears without hit. The page offset is always copied through on a hit. miss_pulse follows a missed request exactly one cycle later and never comes without one. The questions of which entry should match are left to the bench scenarios, because only known table contents give a correct answer. These scenarios cover the space-flag selection, shared versus private process tags, each page size including the reserved codes, the lowest-index choice, the timing of a write and the read-back priority.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int ADDR_W   = 32;
    localparam int BASE_OFF = 12;
    localparam int PN_W     = ADDR_W - BASE_OFF;
    localparam int SIZE_W   = 3;
    localparam int MAX_CODE = 4;

    // Mask of page-number bits that take part in the compare.
    function automatic logic [PN_W-1:0] pn_mask(input logic [SIZE_W-1:0] code);
        logic [PN_W-1:0] ones;
        int unsigned sh;
        ones = '1;
        sh = (int'(code) <= MAX_CODE) ? 2 * int'(code) : 0;
        return ones << sh;
    endfunction
endpackage

// File: rtl/tlb_entry_match.sv
module tlb_entry_match
    import tlb_pkg::*;
#(
    parameter int PID_W = 8
) (
    input  logic              ent_valid,
    input  logic              ent_space,
    input  logic [PID_W-1:0]  ent_tid,
    input  logic [PN_W-1:0]   ent_epn,
    input  logic [SIZE_W-1:0] ent_size,
    input  logic              as_bit,
    input  logic [PID_W-1:0]  pid,
    input  logic [PN_W-1:0]   req_pn,
    output logic              match
);
    logic pn_eq;
    logic pid_ok;

    always_comb begin
        pn_eq  = ((req_pn ^ ent_epn) & pn_mask(ent_size)) == '0;
        pid_ok = (ent_tid == '0) || (ent_tid == pid);
        match  = ent_valid && (ent_space == as_bit) && pid_ok && pn_eq;
    end
endmodule

// File: rtl/tlb_prio_select.sv
module tlb_prio_select #(
    parameter int N     = 16,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     match_vec,
    output logic             any_match,
    output logic             many_match,
    output logic [IDX_W-1:0] win_idx
);
    always_comb begin
        any_match  = |match_vec;
        many_match = (match_vec & (match_vec - 1'b1)) != '0;
        win_idx    = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (match_vec[i]) win_idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/tlb_lookup_unit.sv
module tlb_lookup_unit
    import tlb_pkg::*;
#(
    parameter int N_ENTRIES = 16,
    parameter int PID_W     = 8,
    parameter int PERM_W    = 4,
    localparam int IDX_W    = $clog2(N_ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_fetch,
    input  logic [31:0]       req_ea,
    input  logic              fetch_space,
    input  logic              data_space,
    input  logic [PID_W-1:0]  cur_pid,
    output logic              hit,
    output logic              multi_hit,
    output logic [IDX_W-1:0]  hit_idx,
    output logic [31:0]       real_addr,
    output logic [PERM_W-1:0] perm_out,
    output logic              miss_pulse,
    input  logic              ld_en,
    input  logic              ld_valid,
    input  logic              ld_space,
    input  logic [PID_W-1:0]  ld_tid,
    input  logic [19:0]       ld_epn,
    input  logic [19:0]       ld_rpn,
    input  logic [2:0]        ld_size,
    input  logic [PERM_W-1:0] ld_perm,
    input  logic              cmd_write,
    input  logic              cmd_read,
    input  logic [IDX_W-1:0]  cmd_idx,
    output logic              st_valid,
    output logic              st_space,
    output logic [PID_W-1:0]  st_tid,
    output logic [19:0]       st_epn,
    output logic [19:0]       st_rpn,
    output logic [2:0]        st_size,
    output logic [PERM_W-1:0] st_perm
);
    typedef struct packed {
        logic              valid;
        logic              space;
        logic [PID_W-1:0]  tid;
        logic [PN_W-1:0]   epn;
        logic [PN_W-1:0]   rpn;
        logic [SIZE_W-1:0] size;
        logic [PERM_W-1:0] perm;
    } entry_t;

    typedef struct packed {
        entry_t [N_ENTRIES-1:0] tbl;
        entry_t                 stg;
        logic                   miss;
    } state_t;

    state_t st_d, st_q;

    logic                 as_bit;
    logic [PN_W-1:0]      req_pn;
    logic [N_ENTRIES-1:0] match_vec;
    logic                 any_match;
    logic                 many_match;
    logic [IDX_W-1:0]     win_idx;
    entry_t               win;
    logic [PN_W-1:0]      win_mask;

    assign as_bit = req_fetch ? fetch_space : data_space;
    assign req_pn = req_ea[ADDR_W-1:BASE_OFF];

    for (genvar g = 0; g < N_ENTRIES; g++) begin : g_cmp
        tlb_entry_match #(.PID_W(PID_W)) u_match (
            .ent_valid (st_q.tbl[g].valid),
            .ent_space (st_q.tbl[g].space),
            .ent_tid   (st_q.tbl[g].tid),
            .ent_epn   (st_q.tbl[g].epn),
            .ent_size  (st_q.tbl[g].size),
            .as_bit    (as_bit),
            .pid       (cur_pid),
            .req_pn    (req_pn),
            .match     (match_vec[g])
        );
    end

    tlb_prio_select #(.N(N_ENTRIES), .IDX_W(IDX_W)) u_prio (
        .match_vec  (match_vec),
        .any_match  (any_match),
        .many_match (many_match),
        .win_idx    (win_idx)
    );

    always_comb begin
        win      = st_q.tbl[win_idx];
        win_mask = pn_mask(win.size);
        hit       = req_valid && any_match;
        multi_hit = hit && many_match;
        if (hit) begin
            hit_idx   = win_idx;
            real_addr = {(win.rpn & win_mask) | (req_pn & ~win_mask),
                         req_ea[BASE_OFF-1:0]};
            perm_out  = win.perm;
        end else begin
            hit_idx   = '0;
            real_addr = '0;
            perm_out  = '0;
        end
    end

    always_comb begin
        st_d      = st_q;
        st_d.miss = req_valid && !any_match;
        if (cmd_write) st_d.tbl[cmd_idx] = st_q.stg;
        if (cmd_read) begin
            st_d.stg = st_q.tbl[cmd_idx];
        end else if (ld_en) begin
            st_d.stg = '{valid: ld_valid, space: ld_space, tid: ld_tid,
                         epn: ld_epn, rpn: ld_rpn, size: ld_size, perm: ld_perm};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign miss_pulse = st_q.miss;
    assign st_valid   = st_q.stg.valid;
    assign st_space   = st_q.stg.space;
    assign st_tid     = st_q.stg.tid;
    assign st_epn     = st_q.stg.epn;
    assign st_rpn     = st_q.stg.rpn;
    assign st_size    = st_q.stg.size;
    assign st_perm    = st_q.stg.perm;
endmodule

// File: rtl/tlb_lookup_checker.sv
module tlb_lookup_checker #(
    parameter int IDX_W  = 4,
    parameter int PERM_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [31:0]       req_ea,
    input logic              hit,
    input logic              multi_hit,
    input logic [IDX_W-1:0]  hit_idx,
    input logic [31:0]       real_addr,
    input logic [PERM_W-1:0] perm_out
    ,input logic             miss_pulse
);
    a_r5_miss_addr_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (real_addr == '0 && hit_idx == '0 && perm_out == '0));

    a_r5_idle_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> !hit);

    a_r6_multi_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
        multi_hit |-> hit);

    a_r4_offset_copied: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> real_addr[11:0] == req_ea[11:0]);

    a_r7_strobe_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !hit) |=> miss_pulse);

    a_r7_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        miss_pulse |-> $past(req_valid && !hit));
endmodule

bind tlb_lookup_unit tlb_lookup_checker #(.IDX_W(IDX_W), .PERM_W(PERM_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ea     (req_ea),
    .hit        (hit),
    .multi_hit  (multi_hit),
    .hit_idx    (hit_idx),
    .real_addr  (real_addr),
    .perm_out   (perm_out),
    .miss_pulse (miss_pulse)
);

// File: tb/tlb_lookup_unit_bench.sv
module tlb_lookup_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 0, req_fetch = 0, fetch_space = 0, data_space = 0;
    logic [31:0] req_ea = '0;
    logic [7:0]  cur_pid = '0;
    logic        hit, multi_hit, miss_pulse;
    logic [3:0]  hit_idx, perm_out;
    logic [31:0] real_addr;
    logic        ld_en = 0, ld_valid = 0, ld_space = 0;
    logic [7:0]  ld_tid = '0;
    logic [19:0] ld_epn = '0, ld_rpn = '0;
    logic [2:0]  ld_size = '0;
    logic [3:0]  ld_perm = '0;
    logic        cmd_write = 0, cmd_read = 0;
    logic [3:0]  cmd_idx = '0;
    logic        st_valid, st_space;
    logic [7:0]  st_tid;
    logic [19:0] st_epn, st_rpn;
    logic [2:0]  st_size;
    logic [3:0]  st_perm;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    tlb_lookup_unit u_tlb_lookup_unit (.*);

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    task automatic look(input bit f, input logic [31:0] ea, input bit isp, input bit dsp,
                        input logic [7:0] pid, input bit eh, input logic [3:0] ei,
                        input logic [31:0] era, input logic [3:0] ep, input bit em,
                        input string rq);
        @(negedge clk);
        req_valid = 1; req_fetch = f; req_ea = ea;
        fetch_space = isp; data_space = dsp; cur_pid = pid;
        #1;
        chk(hit == eh, rq, "hit", 32'(hit), 32'(eh));
        chk(hit_idx == ei, rq, "hit_idx", 32'(hit_idx), 32'(ei));
        chk(real_addr == era, rq, "real_addr", real_addr, era);
        chk(perm_out == ep, rq, "perm_out", 32'(perm_out), 32'(ep));
        chk(multi_hit == em, rq, "multi_hit", 32'(multi_hit), 32'(em));
        @(negedge clk);
        chk(miss_pulse == !eh, "R7", "miss_pulse", 32'(miss_pulse), 32'(!eh));
        req_valid = 0;
    endtask

    task automatic stage(input bit v, input bit s, input logic [7:0] tid,
                         input logic [19:0] epn, input logic [19:0] rpn,
                         input logic [2:0] sz, input logic [3:0] pm);
        @(negedge clk);
        ld_en = 1; ld_valid = v; ld_space = s; ld_tid = tid;
        ld_epn = epn; ld_rpn = rpn; ld_size = sz; ld_perm = pm;
        @(negedge clk);
        ld_en = 0;
    endtask

    task automatic put(input logic [3:0] idx, input bit v, input bit s, input logic [7:0] tid,
                       input logic [19:0] epn, input logic [19:0] rpn,
                       input logic [2:0] sz, input logic [3:0] pm);
        stage(v, s, tid, epn, rpn, sz, pm);
        cmd_write = 1; cmd_idx = idx;
        @(negedge clk);
        cmd_write = 0;
    endtask

    task automatic t_reset;
        #1;
        chk(st_valid == 0 && st_epn == 0 && st_tid == 0, "R10", "staging",
            {st_valid, st_tid, st_epn[15:0]}, 0);
        chk(miss_pulse == 0, "R10", "miss_pulse", 32'(miss_pulse), 0);
        look(0, 32'h0, 0, 0, 8'h0, 0, 0, 0, 0, 0, "R10");
        look(0, 32'h0, 0, 0, 8'h0, 0, 0, 0, 0, 0, "R5");
    endtask

    task automatic t_private_page;
        put(4'd0, 1, 0, 8'h05, 20'h12345, 20'hABCDE, 3'd0, 4'h3);
        look(0, 32'h12345678, 0, 0, 8'h05, 1, 0, 32'hABCDE678, 4'h3, 0, "R1");
        look(0, 32'h12345678, 0, 0, 8'h06, 0, 0, 0, 0, 0, "R3");
        look(0, 32'h12345678, 0, 1, 8'h05, 0, 0, 0, 0, 0, "R1");
        look(0, 32'h12346678, 0, 0, 8'h05, 0, 0, 0, 0, 0, "R1");
        @(negedge clk);
        req_valid = 0; req_ea = 32'h12345678; data_space = 0; cur_pid = 8'h05;
        #1;
        chk(hit == 0 && real_addr == 0, "R5", "idle hit", real_addr, 0);
    endtask

    task automatic t_space_select;
        look(1, 32'h12345ABC, 0, 1, 8'h05, 1, 0, 32'hABCDEABC, 4'h3, 0, "R2");
        look(1, 32'h12345ABC, 1, 0, 8'h05, 0, 0, 0, 0, 0, "R2");
    endtask

    task automatic t_shared_and_sizes;
        put(4'd1, 1, 1, 8'h00, 20'h40000, 20'h80000, 3'd4, 4'h5);
        look(0, 32'h400ABCDE, 0, 1, 8'h09, 1, 4'd1, 32'h800ABCDE, 4'h5, 0, "R3");
        look(0, 32'h401ABCDE, 0, 1, 8'h33, 0, 0, 0, 0, 0, "R4");
        put(4'd2, 1, 0, 8'h00, 20'h56780, 20'h11110, 3'd2, 4'h6);
        look(0, 32'h5678F123, 0, 0, 8'h01, 1, 4'd2, 32'h1111F123, 4'h6, 0, "R4");
        look(0, 32'h5679F123, 0, 0, 8'h01, 0, 0, 0, 0, 0, "R4");
        put(4'd3, 1, 0, 8'h00, 20'h9000A, 20'h0000B, 3'd7, 4'h1);
        look(0, 32'h9000A004, 0, 0, 8'h02, 1, 4'd3, 32'h0000B004, 4'h1, 0, "R4");
        look(0, 32'h9000B004, 0, 0, 8'h02, 0, 0, 0, 0, 0, "R4");
    endtask

    task automatic t_multi;
        put(4'd9, 1, 0, 8'h00, 20'h77777, 20'h99999, 3'd0, 4'h9);
        put(4'd5, 1, 0, 8'h00, 20'h77777, 20'h55555, 3'd0, 4'h7);
        look(0, 32'h77777010, 0, 0, 8'h00, 1, 4'd5, 32'h55555010, 4'h7, 1, "R6");
        put(4'd5, 0, 0, 8'h00, 20'h77777, 20'h55555, 3'd0, 4'h7);
        look(0, 32'h77777010, 0, 0, 8'h00, 1, 4'd9, 32'h99999010, 4'h9, 0, "R6");
    endtask

    task automatic t_write_timing;
        stage(1, 0, 8'h00, 20'hCAFE0, 20'h0BEEF, 3'd0, 4'h2);
        @(negedge clk);
        cmd_write = 1; cmd_idx = 4'd4;
        req_valid = 1; req_fetch = 0; req_ea = 32'hCAFE0123; data_space = 0; cur_pid = 0;
        #1;
        chk(hit == 0, "R8", "hit before edge", 32'(hit), 0);
        @(negedge clk);
        cmd_write = 0;
        #1;
        chk(hit == 1 && hit_idx == 4'd4, "R8", "hit after edge", {hit, hit_idx}, 32'h14);
        chk(real_addr == 32'h0BEEF123, "R8", "real_addr", real_addr, 32'h0BEEF123);
        req_valid = 0;
    endtask

    task automatic t_readback;
        @(negedge clk);
        cmd_read = 1; cmd_idx = 4'd9;
        ld_en = 1; ld_valid = 0; ld_space = 1; ld_tid = 8'hEE; ld_epn = 20'h1;
        ld_rpn = 20'h2; ld_size = 3'd3; ld_perm = 4'hF;
        @(negedge clk);
        cmd_read = 0; ld_en = 0;
        #1;
        chk(st_valid == 1 && st_space == 0 && st_tid == 8'h00, "R9", "flags",
            {st_valid, st_space, st_tid}, 32'h200);
        chk(st_epn == 20'h77777, "R9", "epn", 32'(st_epn), 32'h77777);
        chk(st_rpn == 20'h99999, "R9", "rpn", 32'(st_rpn), 32'h99999);
        chk(st_size == 3'd0 && st_perm == 4'h9, "R9", "size/perm",
            {st_size, st_perm}, 32'h009);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset;
        t_private_page;
        t_space_select;
        t_shared_and_sizes;
        t_multi;
        t_write_timing;
        t_readback;
        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(8 * 50000);
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule